// File: doc/BRIEF.md
# Reorder-Buffer Store/Load Ordering Checker

This block holds the memory-ordering state of an eight-slot reorder buffer. Each slot, once allocated, records whether it holds a store. For a store it also records the effective address once that address has been resolved, and the store data once the producing instruction has broadcast its result. A store whose data was not ready at allocation watches every result broadcast for its producer's tag and captures the value directly into its slot. No separate store queue exists: the live reorder-buffer slots are the store queue.

The issue logic asks the block whether a load may start its memory access. It supplies the load's own slot index and effective address. The block stalls the load while any store that is older in program order and still uncommitted has the same address, or has no address yet. Memory is written only when the store at the head of the buffer commits, so memory writes happen strictly in program order. A flush discards every slot younger than a given index. A discarded store no longer holds any load back.

Top module: `rob_mem_order`

## Requirements
- R1: After reset the buffer is empty: `alloc_tag`=0, `head_tag`=0, and `rob_full`, `head_can_commit`, `mem_wr_en` and `ld_stall` are all 0.
- R2: An accepted allocation takes slot `alloc_tag`, and `alloc_tag` advances by one modulo 8 on the next cycle. With 8 slots live, `rob_full`=1 and an allocation request is ignored. An allocation requested in the same cycle as `flush_valid` is also ignored.
- R3: `ld_stall`=1 when `ld_valid`=1 and a live store older than the load has a resolved address equal to `ld_addr`. A store whose resolved address differs does not stall the load.
- R4: A live store older than the load whose address is not yet resolved stalls the load, whatever `ld_addr` is.
- R5: Age is the distance from `head_tag` modulo 8. Only stores at a smaller distance than `ld_tag` are compared, so a store in the load's own slot or in a younger slot never stalls it, including when the indices wrap past 7.
- R6: When `bc_valid`=1, every live store still waiting on producer tag `bc_tag` captures `bc_value` as its data. This includes a store allocated in the same cycle with `alloc_src_tag`=`bc_tag` and `alloc_data_rdy`=0.
- R7: `head_can_commit`=1 when the head slot is live and either holds a non-store, or holds a store with both address and data present.
- R8: A commit request retires the head slot only when `head_can_commit`=1; otherwise it is ignored. `mem_wr_en` is 1 exactly in the cycle a store retires from the head. In that cycle `mem_wr_addr` and `mem_wr_data` carry that store's address and data.
- R9: A flush with `flush_tag` inside the live range empties every slot younger than `flush_tag`. On the next cycle `alloc_tag`=`flush_tag`+1 modulo 8, and the emptied stores stall no load. A flush whose `flush_tag` lies outside the live range is ignored.
- R10: A store that has committed no longer stalls any load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Request to allocate the tail slot |
| alloc_is_store | input | 1 | The new slot holds a store |
| alloc_src_tag | input | 3 | Tag of the instruction producing the store data |
| alloc_data_rdy | input | 1 | Store data already available at allocation |
| alloc_data | input | 32 | Store data when already available |
| alloc_tag | output | 3 | Slot index the next allocation takes |
| rob_full | output | 1 | All slots live |
| addr_valid | input | 1 | A store address has been resolved |
| addr_tag | input | 3 | Slot of the store whose address is resolved |
| addr_value | input | 32 | Resolved effective address |
| bc_valid | input | 1 | Result broadcast valid |
| bc_tag | input | 3 | Tag of the broadcasting instruction |
| bc_value | input | 32 | Broadcast result value |
| commit_req | input | 1 | Request to retire the head slot |
| head_tag | output | 3 | Slot index of the oldest live entry |
| head_can_commit | output | 1 | Head slot may retire this cycle |
| mem_wr_en | output | 1 | Memory write of the retiring store |
| mem_wr_addr | output | 32 | Address of the retiring store |
| mem_wr_data | output | 32 | Data of the retiring store |
| flush_valid | input | 1 | Discard slots younger than flush_tag |
| flush_tag | input | 3 | Youngest slot kept by the flush |
| ld_valid | input | 1 | Load hazard query valid |
| ld_tag | input | 3 | Slot index of the querying load |
| ld_addr | input | 32 | Effective address of the load |
| ld_stall | output | 1 | Load must not start its memory access |

## Verification
The bench aims at the wraparound case, where a store in slot 5 is older than a load in slot 0. A design that compared raw indices would let that load slip past a matching store, or would stall it on a younger one. It also covers a broadcast that lands in the same cycle as the allocation of the waiting store; a design that missed it would leave the store waiting forever, so the head could never commit. Commit requests against a head store that lacks its data must produce no memory write. Flushes that cut away matching stores must release the load at once, and a design that kept the discarded slots alive would hold the load stalled. A long random phase mixes all of these cases and compares every output with a queue-based model on every clock.

// File: rtl/rob_mo_pkg.sv
// Package: default geometry of the store/load ordering checker.
// Assumes the slot count is a power of two so ages wrap naturally.
package rob_mo_pkg;
    localparam int ROB_DEPTH   = 8;
    localparam int ROB_ADDR_W  = 32;
    localparam int ROB_DATA_W  = 32;
endpackage

// File: rtl/rob_mo_entry.sv
// One reorder-buffer slot as seen by memory ordering: live flag, store
// flag, address (resolved later) and data (captured from a broadcast).
// Assumes alloc_en and kill never target the same slot in one cycle.
module rob_mo_entry #(
    parameter int TAG_W  = 3,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_en,
    input  logic              alloc_st,
    input  logic [TAG_W-1:0]  alloc_src,
    input  logic              alloc_drdy,
    input  logic [DATA_W-1:0] alloc_data,
    input  logic              kill,
    input  logic              addr_we,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_value,
    output logic              e_valid,
    output logic              e_st,
    output logic              e_aok,
    output logic [ADDR_W-1:0] e_addr,
    output logic              e_dok,
    output logic [DATA_W-1:0] e_data
);
    logic [TAG_W-1:0] src_q;
    logic             bc_alloc_hit;
    logic             bc_wait_hit;

    // Broadcast matches for a new slot and for a waiting live store.
    assign bc_alloc_hit = bc_valid && (bc_tag == alloc_src);
    assign bc_wait_hit  = bc_valid && (bc_tag == src_q) && e_valid && e_st && !e_dok;

    // Slot state: allocate, clear, or pick up address and data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_valid <= 1'b0;
            e_st    <= 1'b0;
            e_aok   <= 1'b0;
            e_addr  <= '0;
            e_dok   <= 1'b0;
            e_data  <= '0;
            src_q   <= '0;
        end else if (alloc_en) begin
            e_valid <= 1'b1;
            e_st    <= alloc_st;
            e_aok   <= 1'b0;
            e_addr  <= '0;
            src_q   <= alloc_src;
            if (alloc_drdy) begin
                e_dok  <= 1'b1;
                e_data <= alloc_data;
            end else if (bc_alloc_hit) begin
                e_dok  <= 1'b1;
                e_data <= bc_value;
            end else begin
                e_dok  <= 1'b0;
                e_data <= '0;
            end
        end else if (kill) begin
            e_valid <= 1'b0;
            e_st    <= 1'b0;
            e_aok   <= 1'b0;
            e_dok   <= 1'b0;
        end else begin
            if (addr_we && e_valid && e_st) begin
                e_aok  <= 1'b1;
                e_addr <= addr_in;
            end
            if (bc_wait_hit) begin
                e_dok  <= 1'b1;
                e_data <= bc_value;
            end
        end
    end
endmodule

// File: rtl/rob_mo_ptr.sv
// Head pointer and occupancy count of the reorder buffer; the tail is
// derived. Decides which of allocate, commit and flush take effect.
// Assumes DEPTH == 2**TAG_W.
module rob_mo_ptr #(
    parameter int DEPTH = 8,
    parameter int TAG_W = 3,
    localparam int CNT_W = TAG_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_valid,
    input  logic             commit_req,
    input  logic             head_ok,
    input  logic             flush_valid,
    input  logic [TAG_W-1:0] flush_tag,
    output logic [TAG_W-1:0] head,
    output logic [TAG_W-1:0] tail,
    output logic [CNT_W-1:0] cnt,
    output logic [TAG_W-1:0] flush_rel,
    output logic             full,
    output logic             alloc_acc,
    output logic             commit_acc,
    output logic             flush_acc
);
    logic [CNT_W-1:0] cnt_n;

    // Acceptance of each request against the current occupancy.
    always_comb begin
        flush_rel  = flush_tag - head;
        full       = (cnt == CNT_W'(DEPTH));
        flush_acc  = flush_valid && ({1'b0, flush_rel} < cnt);
        alloc_acc  = alloc_valid && !flush_valid && !full;
        commit_acc = commit_req && (cnt != '0) && head_ok;
        tail       = head + cnt[TAG_W-1:0];
    end

    // Next occupancy: a flush sets it from the kept range.
    always_comb begin
        if (flush_acc)
            cnt_n = {1'b0, flush_rel} + CNT_W'(1) - CNT_W'(commit_acc);
        else
            cnt_n = cnt + CNT_W'(alloc_acc) - CNT_W'(commit_acc);
    end

    // Pointer and count registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head <= '0;
            cnt  <= '0;
        end else begin
            head <= head + TAG_W'(commit_acc);
            cnt  <= cnt_n;
        end
    end
endmodule

// File: rtl/rob_mo_ldchk.sv
// Load hazard search across all live slots. A store stalls the load when
// it is older (smaller age) and its address matches or is unknown.
// Assumes ages are given relative to the current head.
module rob_mo_ldchk #(
    parameter int DEPTH  = 8,
    parameter int TAG_W  = 3,
    parameter int ADDR_W = 32
) (
    input  logic [TAG_W-1:0]             head,
    input  logic [DEPTH-1:0][TAG_W-1:0]  age,
    input  logic [DEPTH-1:0]             v,
    input  logic [DEPTH-1:0]             st,
    input  logic [DEPTH-1:0]             aok,
    input  logic [DEPTH-1:0][ADDR_W-1:0] a,
    input  logic                         ld_valid,
    input  logic [TAG_W-1:0]             ld_tag,
    input  logic [ADDR_W-1:0]            ld_addr,
    output logic                         stall
);
    logic [TAG_W-1:0] ld_age;
    logic [DEPTH-1:0] hit;

    assign ld_age = ld_tag - head;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        // Per-slot hazard: older live store, same or unknown address.
        assign hit[i] = v[i] && st[i] && (age[i] < ld_age) &&
                        (!aok[i] || (a[i] == ld_addr));
    end

    assign stall = ld_valid && (|hit);
endmodule

// File: rtl/rob_mem_order.sv
// Top: memory-ordering view of the reorder buffer. Slots double as the
// store queue; data arrives by broadcast; memory is written only as the
// head store retires. Assumes issue logic obeys rob_full and ld_stall.
module rob_mem_order #(
    parameter int DEPTH  = rob_mo_pkg::ROB_DEPTH,
    parameter int ADDR_W = rob_mo_pkg::ROB_ADDR_W,
    parameter int DATA_W = rob_mo_pkg::ROB_DATA_W,
    localparam int TAG_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic              alloc_is_store,
    input  logic [TAG_W-1:0]  alloc_src_tag,
    input  logic              alloc_data_rdy,
    input  logic [DATA_W-1:0] alloc_data,
    output logic [TAG_W-1:0]  alloc_tag,
    output logic              rob_full,
    input  logic              addr_valid,
    input  logic [TAG_W-1:0]  addr_tag,
    input  logic [ADDR_W-1:0] addr_value,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_value,
    input  logic              commit_req,
    output logic [TAG_W-1:0]  head_tag,
    output logic              head_can_commit,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    input  logic              flush_valid,
    input  logic [TAG_W-1:0]  flush_tag,
    input  logic              ld_valid,
    input  logic [TAG_W-1:0]  ld_tag,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic              ld_stall
);
    localparam int CNT_W = TAG_W + 1;

    logic [TAG_W-1:0]             head, tail, flush_rel;
    logic [CNT_W-1:0]             cnt;
    logic                         full, alloc_acc, commit_acc, flush_acc;
    logic                         head_ok;
    logic [DEPTH-1:0]             v, st, aok, dok;
    logic [DEPTH-1:0][ADDR_W-1:0] a;
    logic [DEPTH-1:0][DATA_W-1:0] d;
    logic [DEPTH-1:0][TAG_W-1:0]  age;

    rob_mo_ptr #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_ptr (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .commit_req(commit_req), .head_ok(head_ok),
        .flush_valid(flush_valid), .flush_tag(flush_tag),
        .head(head), .tail(tail), .cnt(cnt), .flush_rel(flush_rel), .full(full),
        .alloc_acc(alloc_acc), .commit_acc(commit_acc), .flush_acc(flush_acc)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        localparam logic [TAG_W-1:0] IDX = TAG_W'(i);
        logic kill_i;

        // Age of this slot relative to the head.
        assign age[i] = IDX - head;
        // Slot leaves on retirement or when younger than the flush point.
        assign kill_i = (commit_acc && (head == IDX)) ||
                        (flush_acc && v[i] && (age[i] > flush_rel));

        rob_mo_entry #(.TAG_W(TAG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ent (
            .clk(clk), .rst_n(rst_n),
            .alloc_en(alloc_acc && (tail == IDX)),
            .alloc_st(alloc_is_store), .alloc_src(alloc_src_tag),
            .alloc_drdy(alloc_data_rdy), .alloc_data(alloc_data),
            .kill(kill_i),
            .addr_we(addr_valid && (addr_tag == IDX)), .addr_in(addr_value),
            .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_value(bc_value),
            .e_valid(v[i]), .e_st(st[i]), .e_aok(aok[i]), .e_addr(a[i]),
            .e_dok(dok[i]), .e_data(d[i])
        );
    end

    rob_mo_ldchk #(.DEPTH(DEPTH), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_ld (
        .head(head), .age(age), .v(v), .st(st), .aok(aok), .a(a),
        .ld_valid(ld_valid), .ld_tag(ld_tag), .ld_addr(ld_addr), .stall(ld_stall)
    );

    // Head readiness and the in-order memory write of a retiring store.
    always_comb begin
        head_ok         = v[head] && (!st[head] || (aok[head] && dok[head]));
        head_can_commit = head_ok;
        mem_wr_en       = commit_acc && st[head];
        mem_wr_addr     = a[head];
        mem_wr_data     = d[head];
        alloc_tag       = tail;
        head_tag        = head;
        rob_full        = full;
    end
endmodule

// File: rtl/rob_mem_order_chk.sv
// Checker for rob_mem_order: pointer motion and write qualification.
// Assumes it is bound into the top so it can see the occupancy count.
module rob_mem_order_chk #(
    parameter int TAG_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alloc_valid,
    input logic             rob_full,
    input logic [TAG_W-1:0] alloc_tag,
    input logic [TAG_W-1:0] head_tag,
    input logic             head_can_commit,
    input logic             commit_req,
    input logic             mem_wr_en,
    input logic             flush_valid,
    input logic [TAG_W-1:0] flush_tag,
    input logic [TAG_W:0]   cnt,
    input logic             ld_valid,
    input logic             ld_stall
);
    logic [TAG_W-1:0] frel;
    assign frel = flush_tag - head_tag;

    a_r8_write_needs_commit: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (commit_req && head_can_commit));

    a_r2_tail_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && !rob_full && !flush_valid) |=>
        (alloc_tag == TAG_W'($past(alloc_tag) + 1'b1)));

    a_r2_tail_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!alloc_valid && !flush_valid) |=> $stable(alloc_tag));

    a_r8_head_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_req && head_can_commit) |=>
        (head_tag == TAG_W'($past(head_tag) + 1'b1)));

    a_r8_head_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit_req && head_can_commit) |=> $stable(head_tag));

    a_r9_flush_tail: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_valid && ({1'b0, frel} < cnt)) |=>
        (alloc_tag == TAG_W'($past(flush_tag) + 1'b1)));

    a_r3_stall_needs_query: assert property (@(posedge clk) disable iff (!rst_n)
        ld_stall |-> ld_valid);
endmodule

bind rob_mem_order rob_mem_order_chk #(.TAG_W(TAG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .rob_full(rob_full),
    .alloc_tag(alloc_tag), .head_tag(head_tag), .head_can_commit(head_can_commit),
    .commit_req(commit_req), .mem_wr_en(mem_wr_en), .flush_valid(flush_valid),
    .flush_tag(flush_tag), .cnt(cnt), .ld_valid(ld_valid), .ld_stall(ld_stall)
);

// File: tb/rob_mem_order_tb.sv
// Bench: directed scenarios plus random traffic, compared every clock
// against a queue-based model of the slots in program order.
module rob_mem_order_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_valid = 0, alloc_is_store = 0, alloc_data_rdy = 0;
    logic [2:0]  alloc_src_tag = 0;
    logic [31:0] alloc_data = 0;
    logic [2:0]  alloc_tag;
    logic        rob_full;
    logic        addr_valid = 0;
    logic [2:0]  addr_tag = 0;
    logic [31:0] addr_value = 0;
    logic        bc_valid = 0;
    logic [2:0]  bc_tag = 0;
    logic [31:0] bc_value = 0;
    logic        commit_req = 0;
    logic [2:0]  head_tag;
    logic        head_can_commit, mem_wr_en;
    logic [31:0] mem_wr_addr, mem_wr_data;
    logic        flush_valid = 0;
    logic [2:0]  flush_tag = 0;
    logic        ld_valid = 0;
    logic [2:0]  ld_tag = 0;
    logic [31:0] ld_addr = 0;
    logic        ld_stall;

    int total = 0;
    int bad = 0;

    typedef struct {
        bit          st;
        bit          aok;
        logic [31:0] a;
        bit          dok;
        logic [2:0]  src;
        logic [31:0] d;
    } ment_t;
    ment_t q[$];
    int    mh = 0;

    always #5 clk = ~clk;

    rob_mem_order u_dut (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic int rel(logic [2:0] t);
        return (int'(t) - mh + 8) % 8;
    endfunction

    task automatic clear_in();
        alloc_valid = 0; alloc_is_store = 0; alloc_data_rdy = 0;
        alloc_src_tag = 0; alloc_data = 0; addr_valid = 0; bc_valid = 0;
        commit_req = 0; flush_valid = 0; ld_valid = 0;
    endtask

    // One cycle: compare outputs with the model, then advance the model.
    task automatic tick(string lbl);
        int    sz, lr, fr, k;
        bit    es, hok, cacc, facc, aacc;
        ment_t e;
        #1;
        sz = q.size();
        lr = rel(ld_tag);
        es = 0;
        for (int j = 0; j < sz && j < lr; j++)
            if (q[j].st && (!q[j].aok || q[j].a == ld_addr)) es = 1;
        es = es && ld_valid;
        hok = (sz > 0) && (!q[0].st || (q[0].aok && q[0].dok));
        chk({lbl, " R3 ld_stall"}, 32'(ld_stall), 32'(es));
        chk("R7 head_can_commit", 32'(head_can_commit), 32'(hok));
        chk("R2 alloc_tag", 32'(alloc_tag), 32'((mh + sz) % 8));
        chk("R2 rob_full", 32'(rob_full), 32'(sz == 8));
        chk("R8 head_tag", 32'(head_tag), 32'(mh));
        cacc = commit_req && hok;
        chk("R8 mem_wr_en", 32'(mem_wr_en), 32'(cacc && q[0].st));
        if (cacc && q[0].st) begin
            chk("R8 mem_wr_addr", mem_wr_addr, q[0].a);
            chk("R8 mem_wr_data", mem_wr_data, q[0].d);
        end
        fr   = rel(flush_tag);
        facc = flush_valid && (fr < sz);
        aacc = alloc_valid && !flush_valid && (sz < 8);
        if (addr_valid) begin
            k = rel(addr_tag);
            if (k < sz && q[k].st) begin
                e = q[k]; e.aok = 1; e.a = addr_value; q[k] = e;
            end
        end
        if (bc_valid)
            for (int j = 0; j < sz; j++)
                if (q[j].st && !q[j].dok && q[j].src == bc_tag) begin
                    e = q[j]; e.dok = 1; e.d = bc_value; q[j] = e;
                end
        if (facc) while (q.size() > fr + 1) void'(q.pop_back());
        if (cacc) begin void'(q.pop_front()); mh = (mh + 1) % 8; end
        if (aacc) begin
            e.st = alloc_is_store; e.aok = 0; e.a = 0; e.src = alloc_src_tag;
            if (alloc_data_rdy) begin e.dok = 1; e.d = alloc_data; end
            else if (bc_valid && bc_tag == alloc_src_tag) begin e.dok = 1; e.d = bc_value; end
            else begin e.dok = 0; e.d = 0; end
            q.push_back(e);
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_alloc(bit s, logic [2:0] src, bit rdy, logic [31:0] dv);
        clear_in();
        alloc_valid = 1; alloc_is_store = s; alloc_src_tag = src;
        alloc_data_rdy = rdy; alloc_data = dv;
        tick("alloc");
        clear_in();
    endtask

    task automatic probe(string req, logic [2:0] t, logic [31:0] ad, bit exp);
        clear_in();
        ld_valid = 1; ld_tag = t; ld_addr = ad;
        #1;
        chk({req, " directed ld_stall"}, 32'(ld_stall), 32'(exp));
        tick(req);
        clear_in();
    endtask

    initial begin
        #2_000_000;
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1: reset state at the ports
        chk("R1 alloc_tag", 32'(alloc_tag), 0);
        chk("R1 head_tag", 32'(head_tag), 0);
        chk("R1 rob_full", 32'(rob_full), 0);
        chk("R1 head_can_commit", 32'(head_can_commit), 0);
        chk("R1 mem_wr_en", 32'(mem_wr_en), 0);
        chk("R1 ld_stall", 32'(ld_stall), 0);
        @(negedge clk);

        // R2: fill, overfill, drain
        for (int i = 0; i < 9; i++) do_alloc(0, 0, 1, 0);
        chk("R2 full after 8", 32'(rob_full), 1);
        chk("R2 tail wrapped", 32'(alloc_tag), 0);
        for (int i = 0; i < 8; i++) begin commit_req = 1; tick("R8 drain"); end
        clear_in();
        for (int i = 0; i < 5; i++) do_alloc(0, 0, 1, 0);
        for (int i = 0; i < 5; i++) begin commit_req = 1; tick("R8 drain"); end
        clear_in();
        chk("R8 head at 5", 32'(head_tag), 5);

        // Slots: 5 store (waits on tag 2), 6 other, 7 store ready, 0 load
        do_alloc(1, 3'd2, 0, 0);
        do_alloc(0, 0, 1, 0);
        do_alloc(1, 3'd4, 1, 32'hAA);
        do_alloc(0, 0, 1, 0);
        probe("R4", 3'd0, 32'h100, 1);
        addr_valid = 1; addr_tag = 3'd5; addr_value = 32'h100; tick("R4");
        addr_valid = 1; addr_tag = 3'd7; addr_value = 32'h200; tick("R4");
        clear_in();
        probe("R3 miss", 3'd0, 32'h300, 0);
        probe("R3 hit", 3'd0, 32'h200, 1);
        probe("R5 younger", 3'd6, 32'h200, 0);
        probe("R5 wrap older", 3'd6, 32'h100, 1);
        probe("R5 own slot", 3'd5, 32'h100, 0);

        commit_req = 1;
        #1;
        chk("R7 store without data", 32'(head_can_commit), 0);
        chk("R8 ignored commit", 32'(mem_wr_en), 0);
        tick("R8");
        clear_in();
        bc_valid = 1; bc_tag = 3'd2; bc_value = 32'h55; tick("R6");
        clear_in();
        #1;
        chk("R6 data captured", 32'(head_can_commit), 1);
        commit_req = 1;
        #1;
        chk("R8 write enable", 32'(mem_wr_en), 1);
        chk("R8 write addr", mem_wr_addr, 32'h100);
        chk("R8 write data", mem_wr_data, 32'h55);
        tick("R8");
        clear_in();
        probe("R10 retired store", 3'd0, 32'h100, 0);

        // R9: keep slot 6, drop 7 and 0
        flush_valid = 1; flush_tag = 3'd6; alloc_valid = 1; tick("R9");
        clear_in();
        chk("R9 tail after flush", 32'(alloc_tag), 7);
        probe("R9 flushed store", 3'd0, 32'h200, 0);
        commit_req = 1; tick("R9"); clear_in();

        // R6: broadcast in the allocation cycle
        bc_valid = 1; bc_tag = 3'd3; bc_value = 32'h77;
        alloc_valid = 1; alloc_is_store = 1; alloc_src_tag = 3'd3;
        tick("R6");
        clear_in();
        addr_valid = 1; addr_tag = 3'd7; addr_value = 32'h40; tick("R6");
        clear_in();
        commit_req = 1;
        #1;
        chk("R6 same-cycle data", mem_wr_data, 32'h77);
        tick("R6");
        clear_in();

        // Random traffic against the model
        for (int n = 0; n < 4000; n++) begin
            int sz;
            sz = q.size();
            alloc_valid    = ($urandom % 3) != 0;
            alloc_is_store = $urandom % 2;
            alloc_src_tag  = 3'($urandom);
            alloc_data_rdy = ($urandom % 3) == 0;
            alloc_data     = $urandom;
            addr_valid     = ($urandom % 2);
            addr_tag       = 3'($urandom);
            addr_value     = 32'h100 + 32'(4 * ($urandom % 3));
            bc_valid       = ($urandom % 2);
            bc_tag         = 3'($urandom);
            bc_value       = $urandom;
            commit_req     = ($urandom % 3) != 0;
            flush_valid    = ($urandom % 25) == 0;
            flush_tag      = (sz > 0) ? 3'((mh + ($urandom % sz)) % 8) : 3'($urandom);
            ld_valid       = ($urandom % 4) != 0;
            ld_tag         = 3'($urandom);
            ld_addr        = 32'h100 + 32'(4 * ($urandom % 3));
            tick("R5 random");
        end
        clear_in();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule